// File: doc/BRIEF.md
# CAN Receive Bit Sampler

This block turns an oversampled CAN receive line into a stream of bit decisions. A fast system clock samples the line. After reset, or after a request from downstream logic, the block waits for the line to go dominant (logic 0). That synchronized dominant sample becomes the start-of-frame instant and the first timing anchor. From that anchor the block takes one decision per nominal bit time, placed a programmable number of clocks into the bit.

Every recessive-to-dominant transition that arrives before the next scheduled decision moves the anchor to that transition. The decision after it then falls exactly one sample offset later. Later decisions follow at whole bit periods from the anchor. This hard resynchronization lets a receiver whose clock is not exactly matched stay aligned with the transmitter. Each decision leaves the block as a one-clock strobe with the bit value and a running bit index. The index counts every bit on the wire, stuff bits included. A frame parser downstream decides when a frame has ended and pulses the return-to-idle input.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset, `bit_valid` is 0 and `bit_index` is 0.
- R2: While idle and the line stays recessive (1), no strobe is produced.
- R3: In idle, the first synchronized dominant sample anchors the frame. The strobe for bit 0 appears `sample_offset + 3` clocks after the line is driven low, carrying value 0 and index 0. Latency is two synchronizer stages plus one output register.
- R4: With no falling edges between decisions, later strobes follow every `cycles_per_bit` clocks. Each carries the line value that the synchronizer saw at the decision point.
- R5: A falling edge seen in a cycle that is not a decision cycle moves the anchor. The next decision is taken `sample_offset` clocks after that edge, and whole bit periods follow from there.
- R6: A falling edge that coincides with a decision cycle is not used as an anchor, so the schedule continues at `cycles_per_bit` spacing.
- R7: `bit_index` equals 0 on the first strobe after idle and rises by exactly 1 on each following strobe.
- R8: `bit_valid` is high for exactly one clock per decision.
- R9: A cycle with `idle_req` high produces no strobe in the next cycle. It also clears `bit_index` to 0 and returns the block to waiting for a dominant level. If the line is already low, the next cycle acts as a new start of frame.
- R10: `cycles_per_bit` and `sample_offset` are run-time inputs. Allowed values are `cycles_per_bit` of at least 4 and `sample_offset` from 1 to `cycles_per_bit - 1`. The minimum of 4 clocks per bit is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the line |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Raw CAN receive line, 0 = dominant |
| cycles_per_bit | input | CNT_W | Clocks per nominal bit |
| sample_offset | input | CNT_W | Clocks from bit start to decision point |
| idle_req | input | 1 | Return to idle, clear bit index |
| bit_valid | output | 1 | One-clock strobe per decided bit |
| bit_value | output | 1 | Decided bit value |
| bit_index | output | IDX_W | Index of the decided bit, 0 = start of frame |

## Verification
The bench first drives frames whose bit period equals the configured one. This shows the pure periodic schedule. It then drives frames that are slower and faster than the configured rate, where only edge-driven re-anchoring keeps the decisions inside the right bits. A dedicated pattern places a falling edge exactly on a decision cycle, which separates "sample wins" from "edge wins". A run at four clocks per bit probes the tightest timing. Further directed runs cover a long recessive idle, and a return-to-idle while the line is held dominant, which must restart the count from zero.

// File: rtl/can_bit_sampler_pkg.sv
package can_bit_sampler_pkg;

    typedef enum logic {
        ST_WAIT_DOM = 1'b0,
        ST_TRACK    = 1'b1
    } cbs_state_e;

endpackage

// File: rtl/cbs_line_sync.sv
module cbs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_raw,
    output logic rx_lvl,
    output logic rx_fall
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Recessive reset value so no false edge appears after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], rx_raw};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign rx_lvl  = chain_q[STAGES-1];
    assign rx_fall = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/cbs_sample_ctrl.sv
module cbs_sample_ctrl
    import can_bit_sampler_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_lvl,
    input  logic             rx_fall,
    input  logic [CNT_W-1:0] cycles_per_bit,
    input  logic [CNT_W-1:0] sample_offset,
    input  logic             idle_req,
    output logic             bit_valid,
    output logic             bit_value,
    output logic [IDX_W-1:0] bit_index
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        cbs_state_e       st;
        logic [CNT_W-1:0] remain;   // clocks left until the decision point
        logic [IDX_W-1:0] count;    // bits decided since idle
        logic             vld;
        logic             val;
        logic [IDX_W-1:0] idx;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        st:     ST_WAIT_DOM,
        remain: '0,
        count:  '0,
        vld:    1'b0,
        val:    1'b1,
        idx:    '0
    };

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.vld = 1'b0;
        if (idle_req) begin
            ctrl_d.st     = ST_WAIT_DOM;
            ctrl_d.remain = '0;
            ctrl_d.count  = '0;
            ctrl_d.idx    = '0;
        end else begin
            unique case (ctrl_q.st)
                ST_WAIT_DOM: begin
                    if (!rx_lvl) begin
                        // This sample is the start of frame and the anchor.
                        ctrl_d.st     = ST_TRACK;
                        ctrl_d.remain = sample_offset - CNT_ONE;
                    end
                end
                ST_TRACK: begin
                    if (ctrl_q.remain == '0) begin
                        // Decision point; a coincident edge is not an anchor.
                        ctrl_d.vld    = 1'b1;
                        ctrl_d.val    = rx_lvl;
                        ctrl_d.idx    = ctrl_q.count;
                        ctrl_d.count  = ctrl_q.count + IDX_ONE;
                        ctrl_d.remain = cycles_per_bit - CNT_ONE;
                    end else if (rx_fall) begin
                        ctrl_d.remain = sample_offset - CNT_ONE;
                    end else begin
                        ctrl_d.remain = ctrl_q.remain - CNT_ONE;
                    end
                end
                default: ctrl_d = CTRL_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign bit_valid = ctrl_q.vld;
    assign bit_value = ctrl_q.val;
    assign bit_index = ctrl_q.idx;

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
    parameter int CNT_W       = 16,
    parameter int IDX_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic [CNT_W-1:0] cycles_per_bit,
    input  logic [CNT_W-1:0] sample_offset,
    input  logic             idle_req,
    output logic             bit_valid,
    output logic             bit_value,
    output logic [IDX_W-1:0] bit_index
);

    logic rx_lvl;
    logic rx_fall;

    cbs_line_sync #(
        .STAGES (SYNC_STAGES)
    ) i_line_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_raw  (rx_line),
        .rx_lvl  (rx_lvl),
        .rx_fall (rx_fall)
    );

    cbs_sample_ctrl #(
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) i_sample_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_lvl         (rx_lvl),
        .rx_fall        (rx_fall),
        .cycles_per_bit (cycles_per_bit),
        .sample_offset  (sample_offset),
        .idle_req       (idle_req),
        .bit_valid      (bit_valid),
        .bit_value      (bit_value),
        .bit_index      (bit_index)
    );

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle_req,
    input logic             bit_valid,
    input logic [IDX_W-1:0] bit_index
);

    logic [IDX_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (idle_req) begin
            seen_q <= '0;
        end else if (bit_valid) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    // R8: one clock per decided bit
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R7: index counts strobes since idle
    a_r7_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (bit_index == seen_q));

    // R9: no strobe right after a return-to-idle request
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |=> !bit_valid);

    // R9: index cleared by a return-to-idle request
    a_r9_index_clear: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |=> (bit_index == '0));

endmodule

bind can_bit_sampler cbs_checker #(
    .IDX_W (IDX_W)
) i_cbs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_req  (idle_req),
    .bit_valid (bit_valid),
    .bit_index (bit_index)
);

// File: tb/test_can_bit_sampler.sv
module test_can_bit_sampler;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int IDX_W      = 8;
    localparam int LAT        = 3;
    localparam int NUM_VEC    = 5;

    typedef struct packed {
        logic [7:0]  cpb;
        logic [7:0]  off;
        logic [7:0]  per;
        logic [15:0] bits;
        logic [7:0]  nb;
        logic [7:0]  tag;
    } vec_t;

    // tag: 4 = periodic, 5 = resync, 6 = edge on decision, 10 = minimum rate
    localparam vec_t VECS [NUM_VEC] = '{
        '{cpb: 8'd10, off: 8'd7, per: 8'd10, bits: 16'b0100_1110_1010_0000, nb: 8'd12, tag: 8'd4},
        '{cpb: 8'd8,  off: 8'd5, per: 8'd9,  bits: 16'b0101_1001_0110_1000, nb: 8'd14, tag: 8'd5},
        '{cpb: 8'd12, off: 8'd8, per: 8'd11, bits: 16'b0010_1101_0011_0100, nb: 8'd14, tag: 8'd5},
        '{cpb: 8'd4,  off: 8'd2, per: 8'd4,  bits: 16'b0110_0101_1100_1010, nb: 8'd16, tag: 8'd10},
        '{cpb: 8'd10, off: 8'd5, per: 8'd5,  bits: 16'b0010_0000_0000_0000, nb: 8'd8,  tag: 8'd6}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rx_line;
    logic [CNT_W-1:0] cycles_per_bit;
    logic [CNT_W-1:0] sample_offset;
    logic             idle_req;
    logic             bit_valid;
    logic             bit_value;
    logic [IDX_W-1:0] bit_index;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    can_bit_sampler #(
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) i_can_bit_sampler (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_line        (rx_line),
        .cycles_per_bit (cycles_per_bit),
        .sample_offset  (sample_offset),
        .idle_req       (idle_req),
        .bit_valid      (bit_valid),
        .bit_value      (bit_value),
        .bit_index      (bit_index)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_name(input int tag);
        case (tag)
            4:       return "R4";
            5:       return "R5";
            6:       return "R6";
            default: return "R10";
        endcase
    endfunction

    function automatic logic wave(input vec_t v, input int t);
        if (t < int'(v.nb) * int'(v.per)) return v.bits[15 - t / int'(v.per)];
        return 1'b1;
    endfunction

    task automatic run_vector(input vec_t v);
        int    total;
        int    et [64];
        logic  ev [64];
        int    ne;
        int    nxt;
        logic  prv;
        int    k;
        string req;
        total = int'(v.nb) * int'(v.per) + 2 * int'(v.cpb) + 8;
        req   = tag_name(int'(v.tag));
        // expected decisions from the anchor rule
        ne  = 0;
        nxt = -1;
        prv = 1'b1;
        for (int t = 0; t < total; t++) begin
            logic cur;
            cur = wave(v, t);
            if (nxt < 0) begin
                if (!cur) nxt = t + int'(v.off);
            end else if (t == nxt) begin
                if (t + LAT < total && ne < 64) begin
                    et[ne] = t;
                    ev[ne] = cur;
                    ne++;
                end
                nxt = nxt + int'(v.cpb);
            end else if (prv && !cur) begin
                nxt = t + int'(v.off);
            end
            prv = cur;
        end
        // return to idle with the line recessive
        @(negedge clk);
        cycles_per_bit = CNT_W'(v.cpb);
        sample_offset  = CNT_W'(v.off);
        rx_line  = 1'b1;
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
        for (int p = 0; p < 5; p++) begin
            check(!bit_valid, "R9", "strobe after return to idle", int'(bit_valid), 0);
            @(negedge clk);
        end
        // drive the frame and compare strobes
        k = 0;
        for (int s = 0; s < total; s++) begin
            bit expect_now;
            expect_now = (k < ne) && (et[k] + LAT == s);
            if (expect_now) begin
                check(bit_valid, (k == 0) ? "R3" : req, "strobe present", int'(bit_valid), 1);
                check(bit_value == ev[k], (k == 0) ? "R3" : req, "bit value",
                      int'(bit_value), int'(ev[k]));
                check(bit_index == IDX_W'(k), "R7", "bit index", int'(bit_index), k);
                k++;
            end else if (bit_valid) begin
                check(1'b0, "R8", "unexpected strobe at step", s, -1);
            end
            rx_line = wave(v, s);
            @(negedge clk);
        end
        check(k == ne, req, "decisions observed", k, ne);
    endtask

    initial begin
        rst_n          = 1'b0;
        rx_line        = 1'b1;
        idle_req       = 1'b0;
        cycles_per_bit = CNT_W'(10);
        sample_offset  = CNT_W'(7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bit_valid, "R1", "strobe after reset", int'(bit_valid), 0);
        check(bit_index == '0, "R1", "index after reset", int'(bit_index), 0);

        begin
            int quiet_strobes;
            quiet_strobes = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (bit_valid) quiet_strobes++;
            end
            check(quiet_strobes == 0, "R2", "strobes while idle recessive", quiet_strobes, 0);
        end

        for (int i = 0; i < NUM_VEC; i++) begin
            run_vector(VECS[i]);
        end

        // R9: return to idle while the line stays dominant restarts at once
        begin
            int s0_off;
            cycles_per_bit = CNT_W'(8);
            sample_offset  = CNT_W'(4);
            s0_off = 4;
            rx_line = 1'b0;
            repeat (30) @(negedge clk);
            idle_req = 1'b1;
            @(negedge clk);
            idle_req = 1'b0;
            for (int i = 1; i <= s0_off + 1; i++) begin
                check(!bit_valid, "R9", "strobe before restart decision", int'(bit_valid), 0);
                @(negedge clk);
            end
            check(bit_valid, "R9", "restart strobe present", int'(bit_valid), 1);
            check(bit_index == '0, "R9", "restart index", int'(bit_index), 0);
            check(bit_value == 1'b0, "R9", "restart value", int'(bit_value), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule